// File: doc/BRIEF.md
# Zero-Address Stack Evaluation Unit

This block evaluates arithmetic expressions written in stack form. The operands live in a small on-chip stack of registers. A pointer names the next free slot. A host issues one command at a time:

- a load-and-push, which takes a word from data memory and places it on the stack;
- a pop-and-store, which writes the top word back to memory;
- two binary operations (add and multiply), which combine the two uppermost entries into one;
- a unary negate, which rewrites the top entry in place.

Every slot that a pop or a binary operation frees is scrubbed to zero in the same cycle, so no stale operand remains in the array. Commands that would run past either end of the stack do not change it. Such a command sets a sticky error flag and still completes with the normal `done` pulse.

Data memory is reached through one synchronous port. A read returns data on the cycle after the address is presented. A write takes effect at the clock edge on which `mem_we` is high.

Top module: `stk_eval`

## Requirements
- R1: After reset, `level` is 0, `err`, `done` and `busy` are low, and `tos_data` is 0.
- R2: A command is taken on a rising edge where `cmd_valid` is high and `busy` is low. `busy` then stays high until completion. The `done` pulse appears in the cycle after the second edge following acceptance for a push, and in the cycle after the first edge for every other code.
- R3: Code 0 (push) reads memory at `cmd_addr`, stores that word in the free slot, and raises `level` by one.
- R4: Code 1 (pop) writes the top entry to memory at `cmd_addr` and lowers `level` by one. The freed slot becomes zero.
- R5: Code 2 (add) and code 3 (multiply) combine the top entry with the entry beneath it. The sum is taken modulo 2^DW, and the product keeps its low DW bits. The result replaces the lower operand, `level` drops by one, and the freed slot becomes zero.
- R6: Code 4 (negate) replaces the top entry with its two's complement and leaves `level` unchanged.
- R7: A push while `level` equals DEPTH sets `err` and leaves the stack and `level` unchanged.
- R8: A pop or negate on an empty stack, or an add or multiply with fewer than two entries, sets `err` and leaves the stack unchanged.
- R9: `err` stays high once set, through later commands, until reset.
- R10: `done` is high for exactly one cycle per command, and `busy` is low in that cycle.
- R11: The sequence push X, push Y, multiply, push W, push U, multiply, add, pop Z stores X·Y+W·U (mod 2^DW) at Z and returns `level` to its starting value.
- R12: Codes 5, 6 and 7 complete with a `done` pulse and change neither the stack, `level` nor `err`.
- R13: `tos_data` shows the entry at `level`-1, or entry 0 when the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | AW | Memory address for push and pop |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky overflow/underflow flag |
| level | output | $clog2(DEPTH+1) | Number of occupied entries |
| tos_data | output | DW | Top entry (entry 0 when empty) |
| mem_addr | output | AW | Data memory address |
| mem_we | output | 1 | Data memory write strobe |
| mem_wdata | output | DW | Data memory write data |
| mem_rdata | input | DW | Data memory read data, one cycle after address |

## Verification
The unit is exercised three ways:

- **The R11 expression.** Its chosen operands give products that overflow the data width. This separates correct low-word truncation and right-operand pairing from a design that only happens to return to level zero.
- **Directed edge cases.** A fill to DEPTH with one extra push, pops and operations on a stack too shallow for them, and pops down to empty each expose a different fault. The first shows whether a full stack is guarded. The second shows whether the pointer wraps below zero. The third shows whether freed slots are really scrubbed.
- **A long seeded random mix.** It weights pushes above the consuming commands and includes the unused codes. This drives the stack through every fill level and compares level, top entry, flag, latency and stored memory words after every command.

// File: rtl/stk_eval_pkg.sv
package stk_eval_pkg;

   localparam logic [2:0] OPC_PUSH = 3'd0;
   localparam logic [2:0] OPC_POP  = 3'd1;
   localparam logic [2:0] OPC_ADD  = 3'd2;
   localparam logic [2:0] OPC_MUL  = 3'd3;
   localparam logic [2:0] OPC_NEG  = 3'd4;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_EXEC = 2'd1,
      SEQ_LOAD = 2'd2
   } seq_state_e;

endpackage

// File: rtl/stk_eval_alu.sv
module stk_eval_alu #(
   parameter int DW       = 16,
   parameter bit FAST_MUL = 1'b1
) (
   input  logic [2:0]    op,
   input  logic [DW-1:0] top_val,
   input  logic [DW-1:0] nxt_val,
   output logic [DW-1:0] result
);
   import stk_eval_pkg::*;

   logic [DW-1:0] prod;

   generate
      if (FAST_MUL) begin : g_mul_native
         assign prod = nxt_val * top_val;
      end else begin : g_mul_shift
         always_comb begin
            prod = '0;
            for (int i = 0; i < DW; i++) begin
               if (top_val[i]) prod = prod + (nxt_val << i);
            end
         end
      end
   endgenerate

   always_comb begin
      case (op)
         OPC_ADD: result = nxt_val + top_val;
         OPC_MUL: result = prod;
         OPC_NEG: result = '0 - top_val;
         default: result = top_val;
      endcase
   end

endmodule

// File: rtl/stk_eval_store.sv
module stk_eval_store #(
   parameter int DW    = 16,
   parameter int DEPTH = 8,
   parameter int IW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic          clr_en,
   input  logic [IW-1:0] clr_idx,
   input  logic [IW-1:0] rd_a_idx,
   output logic [DW-1:0] rd_a,
   input  logic [IW-1:0] rd_b_idx,
   output logic [DW-1:0] rd_b
);

   logic [DW-1:0] ent [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ent[g] <= '0;
            end else if (wr_en && wr_idx == IW'(g)) begin
               ent[g] <= wr_data;
            end else if (clr_en && clr_idx == IW'(g)) begin
               ent[g] <= '0;
            end
         end
      end
   endgenerate

   assign rd_a = ent[rd_a_idx];
   assign rd_b = ent[rd_b_idx];

   // R5: a result write and a scrub never aim at the same slot
   assert_port_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && clr_en && wr_idx == clr_idx));

endmodule

// File: rtl/stk_eval.sv
module stk_eval #(
   parameter int DW       = 16,
   parameter int AW       = 8,
   parameter int DEPTH    = 8,
   parameter bit FAST_MUL = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_valid,
   input  logic [2:0]                 cmd_op,
   input  logic [AW-1:0]              cmd_addr,
   output logic                       busy,
   output logic                       done,
   output logic                       err,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic [DW-1:0]              tos_data,
   output logic [AW-1:0]              mem_addr,
   output logic                       mem_we,
   output logic [DW-1:0]              mem_wdata,
   input  logic [DW-1:0]              mem_rdata
);
   import stk_eval_pkg::*;

   localparam int SPW = $clog2(DEPTH + 1);
   localparam int IW  = $clog2(DEPTH);
   localparam logic [SPW-1:0] LVL_FULL = SPW'(DEPTH);
   localparam logic [SPW-1:0] LVL_ONE  = SPW'(1);
   localparam logic [SPW-1:0] LVL_TWO  = SPW'(2);

   if (DEPTH < 2) begin : g_bad_depth
      $error("stk_eval: DEPTH must be at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("stk_eval: DW must be at least 2");
   end
   if (AW < 1) begin : g_bad_aw
      $error("stk_eval: AW must be at least 1");
   end

   seq_state_e     st_q;
   logic [2:0]     op_q;
   logic [AW-1:0]  addr_q;
   logic [SPW-1:0] sp_q;
   logic           done_q;
   logic           err_q;

   logic [SPW-1:0] sp_m1, sp_m2;
   logic [IW-1:0]  idx_top, idx_nxt, idx_free, rd_top_idx;
   logic [DW-1:0]  top_val, nxt_val, alu_res;
   logic           fault, go;
   logic           wr_en, clr_en;
   logic [IW-1:0]  wr_idx, clr_idx;
   logic [DW-1:0]  wr_data;

   assign sp_m1      = sp_q - LVL_ONE;
   assign sp_m2      = sp_q - LVL_TWO;
   assign idx_top    = sp_m1[IW-1:0];
   assign idx_nxt    = sp_m2[IW-1:0];
   assign idx_free   = sp_q[IW-1:0];
   assign rd_top_idx = (sp_q == '0) ? '0 : idx_top;

   stk_eval_store #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .clr_en   (clr_en),
      .clr_idx  (clr_idx),
      .rd_a_idx (rd_top_idx),
      .rd_a     (top_val),
      .rd_b_idx (idx_nxt),
      .rd_b     (nxt_val)
   );

   stk_eval_alu #(.DW(DW), .FAST_MUL(FAST_MUL)) u_alu (
      .op      (op_q),
      .top_val (top_val),
      .nxt_val (nxt_val),
      .result  (alu_res)
   );

   always_comb begin
      case (op_q)
         OPC_PUSH:         fault = (sp_q == LVL_FULL);
         OPC_POP, OPC_NEG: fault = (sp_q == '0);
         OPC_ADD, OPC_MUL: fault = (sp_q < LVL_TWO);
         default:          fault = 1'b0;
      endcase
   end

   assign go = (st_q == SEQ_EXEC) && !fault;

   always_comb begin
      wr_en   = 1'b0;
      wr_idx  = idx_free;
      wr_data = mem_rdata;
      clr_en  = 1'b0;
      clr_idx = idx_top;
      if (st_q == SEQ_LOAD) begin
         wr_en = 1'b1;
      end else if (go) begin
         case (op_q)
            OPC_ADD, OPC_MUL: begin
               wr_en   = 1'b1;
               wr_idx  = idx_nxt;
               wr_data = alu_res;
               clr_en  = 1'b1;
            end
            OPC_NEG: begin
               wr_en   = 1'b1;
               wr_idx  = idx_top;
               wr_data = alu_res;
            end
            OPC_POP: clr_en = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         op_q   <= '0;
         addr_q <= '0;
         sp_q   <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            SEQ_IDLE: begin
               if (cmd_valid) begin
                  op_q   <= cmd_op;
                  addr_q <= cmd_addr;
                  st_q   <= SEQ_EXEC;
               end
            end
            SEQ_EXEC: begin
               if (fault) begin
                  err_q  <= 1'b1;
                  done_q <= 1'b1;
                  st_q   <= SEQ_IDLE;
               end else if (op_q == OPC_PUSH) begin
                  st_q <= SEQ_LOAD;
               end else begin
                  done_q <= 1'b1;
                  st_q   <= SEQ_IDLE;
                  if (op_q == OPC_POP || op_q == OPC_ADD || op_q == OPC_MUL) sp_q <= sp_m1;
               end
            end
            SEQ_LOAD: begin
               sp_q   <= sp_q + LVL_ONE;
               done_q <= 1'b1;
               st_q   <= SEQ_IDLE;
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != SEQ_IDLE);
   assign done      = done_q;
   assign err       = err_q;
   assign level     = sp_q;
   assign tos_data  = top_val;
   assign mem_addr  = addr_q;
   assign mem_we    = go && (op_q == OPC_POP);
   assign mem_wdata = top_val;

   assert_sp_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sp_q <= LVL_FULL);
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   assert_push_grow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_LOAD) |=> (sp_q == $past(sp_q) + LVL_ONE));
   assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_EXEC && fault) |=> $stable(sp_q));

endmodule

// File: tb/stk_eval_bench.sv
module stk_eval_bench;
   localparam int DW = 16;
   localparam int AW = 8;
   localparam int DEPTH = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic busy, done, err, mem_we;
   logic [3:0] level;
   logic [DW-1:0] tos_data, mem_wdata;
   logic [DW-1:0] mem_rdata;
   logic [AW-1:0] mem_addr;

   logic [DW-1:0] mem [256];
   logic [DW-1:0] ms [DEPTH];
   int m_lvl;
   logic m_err;
   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   stk_eval u_stk_eval (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .busy(busy), .done(done), .err(err),
      .level(level), .tos_data(tos_data), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] f_calc(input logic [2:0] op,
                                            input logic [DW-1:0] lo, input logic [DW-1:0] hi);
      logic [2*DW-1:0] p;
      p = lo * hi;
      case (op)
         3'd2: return lo + hi;
         3'd3: return p[DW-1:0];
         default: return '0 - hi;
      endcase
   endfunction

   function automatic logic [DW-1:0] f_tos();
      return (m_lvl == 0) ? ms[0] : ms[m_lvl-1];
   endfunction

   task automatic do_reset();
      cmd_valid = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_lvl = 0;
      m_err = 1'b0;
      for (int i = 0; i < DEPTH; i++) ms[i] = '0;
      @(negedge clk);
   endtask

   task automatic step(input logic [2:0] op, input logic [AW-1:0] a);
      string req;
      logic bad;
      logic [DW-1:0] exp_mem;
      int lat;
      int exp_lat;
      bad = 1'b0;
      exp_mem = '0;
      exp_lat = (op == 3'd0) ? 3 : 2;
      case (op)
         3'd0: begin
            req = "R3";
            if (m_lvl == DEPTH) bad = 1'b1;
            else begin ms[m_lvl] = mem[a]; m_lvl++; end
         end
         3'd1: begin
            req = "R4";
            if (m_lvl == 0) bad = 1'b1;
            else begin m_lvl--; exp_mem = ms[m_lvl]; ms[m_lvl] = '0; end
         end
         3'd2, 3'd3: begin
            req = "R5";
            if (m_lvl < 2) bad = 1'b1;
            else begin
               ms[m_lvl-2] = f_calc(op, ms[m_lvl-2], ms[m_lvl-1]);
               ms[m_lvl-1] = '0;
               m_lvl--;
            end
         end
         3'd4: begin
            req = "R6";
            if (m_lvl == 0) bad = 1'b1;
            else ms[m_lvl-1] = f_calc(op, '0, ms[m_lvl-1]);
         end
         default: req = "R12";
      endcase
      if (bad) begin
         m_err = 1'b1;
         req = (op == 3'd0) ? "R7" : "R8";
         exp_lat = 2;
      end
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
      @(negedge clk);
      cmd_valid = 1'b0;
      lat = 1;
      while (!done && lat < 20) begin @(negedge clk); lat++; end
      chk("R2", "latency", lat, exp_lat);
      chk("R10", "busy at done", busy, 0);
      chk(req, "level", level, m_lvl);
      chk(req, "err", err, m_err);
      chk("R13", "tos", tos_data, f_tos());
      if (op == 3'd1 && !bad) begin
         @(negedge clk);
         chk("R4", "stored word", mem[a], exp_mem);
      end else begin
         @(negedge clk);
      end
      chk("R10", "done dropped", done, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) mem[i] = DW'($urandom);
      do_reset();
      chk("R1", "level", level, 0);
      chk("R1", "err", err, 0);
      chk("R1", "done", done, 0);
      chk("R1", "busy", busy, 0);
      chk("R1", "tos", tos_data, 0);

      // R11 expression with overflowing products
      mem[10] = 16'd3; mem[11] = 16'd5; mem[12] = 16'h1234; mem[13] = 16'h0100;
      step(3'd0, 8'd10); step(3'd0, 8'd11); step(3'd3, 8'd0);
      step(3'd0, 8'd12); step(3'd0, 8'd13); step(3'd3, 8'd0);
      step(3'd2, 8'd0); step(3'd1, 8'd20);
      chk("R11", "result", mem[20], 16'h340F);
      chk("R11", "level back", level, 0);

      // R4/R13 scrub: after pop to empty, entry 0 reads zero
      mem[30] = 16'hBEEF;
      step(3'd0, 8'd30);
      chk("R13", "tos after push", tos_data, 16'hBEEF);
      step(3'd4, 8'd0);
      chk("R6", "negated", tos_data, 16'h4111);
      step(3'd1, 8'd31);
      chk("R4", "slot scrubbed", tos_data, 0);

      // R12 unused codes
      step(3'd5, 8'd0); step(3'd6, 8'd0); step(3'd7, 8'd0);

      // R7 overflow, then R9 sticky
      for (int i = 0; i < DEPTH; i++) step(3'd0, AW'(40 + i));
      step(3'd0, 8'd60);
      chk("R7", "err on full push", err, 1);
      step(3'd4, 8'd0);
      step(3'd1, 8'd61);
      chk("R9", "err held", err, 1);
      do_reset();
      chk("R9", "err cleared by reset", err, 0);

      // R8 underflow
      step(3'd1, 8'd70);
      step(3'd0, 8'd71);
      step(3'd2, 8'd0);
      step(3'd3, 8'd0);
      chk("R8", "err on short stack", err, 1);
      do_reset();
      step(3'd4, 8'd0);

      // seeded random mix
      for (int i = 0; i < 600; i++) begin
         int r;
         logic [2:0] op;
         if (i % 100 == 0) do_reset();
         r = int'($urandom % 10);
         case (r)
            0, 1, 2, 3: op = 3'd0;
            4, 5:       op = 3'd1;
            6:          op = 3'd2;
            7:          op = 3'd3;
            8:          op = 3'd4;
            default:    op = 3'(5 + $urandom % 3);
         endcase
         step(op, AW'($urandom));
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule